// File: doc/BRIEF.md
# Gapped Two-Pattern Frame Sync Detector

This block looks at a serial chip stream delivered by a clock-recovery front end, one chip for each strobe. It searches for a first start pattern. Once that pattern is found, it counts a programmable gap. At the end of the gap it asks the front end to re-adjust its oscillator phase and passes along a 3-bit correction value. It then opens a window of bounded length in which a second start pattern has to arrive.

Where the window opens depends only on the gap field. Where it closes depends on the gap and on the length of the second pattern. If the second pattern completes inside the window, the block gives a one-clock sync pulse and goes back to searching. If the window runs out, the search for the first pattern starts again on the very next chip. All counting is done in strobes, so clock cycles that carry no strobe do not advance the block.

Top module: `gap_sync_det`

## Requirements
- R1: The 8-bit `gap_cfg` is split into two fields. Bits [7:3] give the gap length G in chips. Bits [2:0] give the phase-correction value.
- R2: Pattern A is matched against the last `len_a` chips (1 to 16). Chips go out most significant first, so the most recent chip is compared with bit 0 of `pat_a`. Bits of `pat_a` at or above `len_a` are ignored. A match needs at least `len_a` chips received since the search started.
- R3: Chip offsets are counted from the last chip of the pattern A match, which is offset 0. `readj_req` pulses for one clock, in the clock after the strobe of the chip at offset G. In that same clock, `readj_phase` holds `gap_cfg[2:0]`.
- R4: `win_active` rises in the clock after the chip at offset G+5. Only chips at offset G+6 or later are compared with pattern B.
- R5: Pattern B (length 1 to 16, masked like pattern A) is accepted only when its final chip lands at an offset from G+len_b+5 to G+len_b+11 inclusive. On acceptance, `sync_found` pulses for one clock and the block returns to the pattern A search.
- R6: If pattern B has not matched by the chip at offset G+len_b+11, the window closes and `win_active` falls. The very next chip is the first chip of a fresh pattern A search.
- R7: The block advances only on clocks where `chip_strobe` is high. Clocks without a strobe change nothing.
- R8: A high `rst` or a high `dis` clears the block: no window, no pulses, and an empty pattern A search.
- R9: When pattern B completes on the chip at offset G+len_b+11, the match wins over the expiry and `sync_found` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dis | input | 1 | Disable; while high, holds the block cleared |
| chip_strobe | input | 1 | Marks a clock that carries a valid chip |
| chip_bit | input | 1 | Chip value |
| pat_a | input | 16 | First start pattern |
| len_a | input | 5 | Length of the first pattern, 1 to 16 |
| pat_b | input | 16 | Second start pattern |
| len_b | input | 5 | Length of the second pattern, 1 to 16 |
| gap_cfg | input | 8 | Gap length [7:3] and phase correction [2:0] |
| sync_found | output | 1 | One-clock pulse when the second pattern is accepted |
| readj_req | output | 1 | One-clock pulse at the end of the gap |
| readj_phase | output | 3 | Phase-correction value, valid while `readj_req` is high |
| win_active | output | 1 | High while the second-pattern window is open |

## Verification
On the last chip of the window, two things can happen at once: pattern B can complete, and the window can expire. The bench provokes this by placing pattern B so that its final chip lands exactly at offset G+len_b+11, for gaps of 0, 10 and 31. It judges the result by requiring `sync_found`. In the same way, placing the final chip one offset later must give no sync pulse and a fresh search for pattern A.

// File: rtl/gap_sync_det.sv
module gap_sync_det #(
  parameter int MAXLEN    = 16,
  parameter int LENW      = $clog2(MAXLEN + 1),
  parameter int OFFW      = 6,
  parameter int OPEN_OFS  = 6,
  parameter int CLOSE_ADD = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dis,
  input  logic              chip_strobe,
  input  logic              chip_bit,
  input  logic [MAXLEN-1:0] pat_a,
  input  logic [LENW-1:0]   len_a,
  input  logic [MAXLEN-1:0] pat_b,
  input  logic [LENW-1:0]   len_b,
  input  logic [7:0]        gap_cfg,
  output logic              sync_found,
  output logic              readj_req,
  output logic [2:0]        readj_phase,
  output logic              win_active
);
  localparam int CW = LENW + 1;
  localparam int LW = OFFW + 1;

  typedef enum logic [1:0] {S_SRCH, S_GAP, S_WIN} st_t;

  st_t              st_q;
  logic [MAXLEN-1:0] sa_q, sb_q;
  logic [LENW-1:0]  fa_q, fb_q;
  logic [OFFW-1:0]  off_q;

  function automatic logic [MAXLEN-1:0] len_mask(input logic [LENW-1:0] len);
    logic [MAXLEN-1:0] m;
    for (int i = 0; i < MAXLEN; i++) m[i] = (i < int'(len));
    return m;
  endfunction

  wire [4:0]        gap    = gap_cfg[7:3];
  wire [MAXLEN-1:0] sa_n   = {sa_q[MAXLEN-2:0], chip_bit};
  wire [MAXLEN-1:0] sb_n   = {sb_q[MAXLEN-2:0], chip_bit};
  wire [OFFW-1:0]   off_n  = off_q + OFFW'(1);
  wire [LW-1:0]     open_o = LW'(gap) + LW'(OPEN_OFS - 1);
  wire [LW-1:0]     lim    = LW'(gap) + LW'(len_b) + LW'(CLOSE_ADD);

  wire hit_a = (((sa_n ^ pat_a) & len_mask(len_a)) == '0) &&
               (CW'(fa_q) + CW'(1) >= CW'(len_a));
  wire hit_b = (((sb_n ^ pat_b) & len_mask(len_b)) == '0) &&
               (CW'(fb_q) + CW'(1) >= CW'(len_b)) &&
               (LW'(off_n) <= lim);

  assign win_active = (st_q == S_WIN);

  always_ff @(posedge clk) begin
    if (rst || dis) begin
      st_q        <= S_SRCH;
      sa_q        <= '0;
      sb_q        <= '0;
      fa_q        <= '0;
      fb_q        <= '0;
      off_q       <= '0;
      sync_found  <= 1'b0;
      readj_req   <= 1'b0;
      readj_phase <= '0;
    end else begin
      sync_found <= 1'b0;
      readj_req  <= 1'b0;
      if (chip_strobe) begin
        case (st_q)
          S_SRCH: begin
            sa_q <= sa_n;
            if (fa_q != LENW'(MAXLEN)) fa_q <= fa_q + LENW'(1);
            if (hit_a) begin
              st_q  <= S_GAP;
              off_q <= '0;
              sb_q  <= '0;
              fb_q  <= '0;
              fa_q  <= '0;
              if (gap == '0) begin
                readj_req   <= 1'b1;
                readj_phase <= gap_cfg[2:0];
              end
            end
          end
          S_GAP: begin
            off_q <= off_n;
            if (LW'(off_n) == LW'(gap)) begin
              readj_req   <= 1'b1;
              readj_phase <= gap_cfg[2:0];
            end
            if (LW'(off_n) == open_o) st_q <= S_WIN;
          end
          S_WIN: begin
            off_q <= off_n;
            sb_q  <= sb_n;
            if (fb_q != LENW'(MAXLEN)) fb_q <= fb_q + LENW'(1);
            if (hit_b) begin
              sync_found <= 1'b1;
              st_q       <= S_SRCH;
              sa_q       <= '0;
              fa_q       <= '0;
            end else if (LW'(off_n) >= lim) begin
              st_q <= S_SRCH;
              sa_q <= '0;
              fa_q <= '0;
            end
          end
          default: st_q <= S_SRCH;
        endcase
      end
    end
  end
endmodule

// File: rtl/gap_sync_det_chk.sv
module gap_sync_det_chk (
  input logic       clk,
  input logic       rst,
  input logic       dis,
  input logic       chip_strobe,
  input logic [7:0] gap_cfg,
  input logic       sync_found,
  input logic       readj_req,
  input logic [2:0] readj_phase,
  input logic       win_active
);
  AST_SYNC_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    sync_found |=> !sync_found); // R5
  AST_SYNC_FROM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_found) |-> $past(win_active) && $past(chip_strobe)); // R5
  AST_READJ_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    readj_req |-> !win_active && !sync_found); // R4
  AST_READJ_PHASE: assert property (@(posedge clk) disable iff (rst)
    readj_req |-> readj_phase == $past(gap_cfg[2:0])); // R3
  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(dis) |-> !win_active && !sync_found && !readj_req); // R8
  AST_WIN_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(win_active) |-> $past(chip_strobe)); // R7
  AST_WIN_CLOSE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    ($fell(win_active) && !$past(dis)) |-> $past(chip_strobe)); // R6
endmodule

bind gap_sync_det gap_sync_det_chk u_chk (
  .clk(clk), .rst(rst), .dis(dis), .chip_strobe(chip_strobe),
  .gap_cfg(gap_cfg), .sync_found(sync_found), .readj_req(readj_req),
  .readj_phase(readj_phase), .win_active(win_active)
);

// File: tb/gap_sync_det_bench.sv
module gap_sync_det_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dis = 1'b0;
  logic        chip_strobe = 1'b0;
  logic        chip_bit = 1'b0;
  logic [15:0] pat_a = 16'hFFC3;
  logic [4:0]  len_a = 5'd8;
  logic [15:0] pat_b = 16'h77A5;
  logic [4:0]  len_b = 5'd8;
  logic [7:0]  gap_cfg = 8'h00;
  logic        sync_found, readj_req, win_active;
  logic [2:0]  readj_phase;

  gap_sync_det u_gap_sync_det (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic o_sync, o_readj, o_win;
  logic [2:0] o_phase;
  int rd_off, win_off, ph;
  bit found;

  // {gap, phase, filler chips d before B, expected sync}
  localparam logic [14:0] VEC [12] = '{
    {5'd0,  3'd1, 6'd5,  1'b1}, {5'd0,  3'd2, 6'd4,  1'b0},
    {5'd0,  3'd3, 6'd11, 1'b1}, {5'd0,  3'd4, 6'd12, 1'b0},
    {5'd10, 3'd5, 6'd15, 1'b1}, {5'd10, 3'd6, 6'd21, 1'b1},
    {5'd10, 3'd7, 6'd22, 1'b0}, {5'd10, 3'd0, 6'd14, 1'b0},
    {5'd31, 3'd5, 6'd36, 1'b1}, {5'd31, 3'd2, 6'd42, 1'b1},
    {5'd31, 3'd6, 6'd43, 1'b0}, {5'd3,  3'd1, 6'd8,  1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chip(input logic b);
    @(negedge clk); chip_bit = b; chip_strobe = 1'b1;
    @(negedge clk); chip_strobe = 1'b0;
    o_sync = sync_found; o_readj = readj_req; o_phase = readj_phase; o_win = win_active;
    @(negedge clk);
  endtask

  task automatic note(input int off);
    if (o_readj && rd_off < 0) begin rd_off = off; ph = int'(o_phase); end
    if (o_win && win_off < 0) win_off = off;
    if (o_sync) found = 1;
  endtask

  task automatic send(input logic [15:0] p, input int len);
    for (int i = len - 1; i >= 0; i--) chip(p[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset sync", int'(sync_found), 0);
    chk("R8 reset readj", int'(readj_req), 0);
    chk("R8 reset win", int'(win_active), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      int g, d;
      g = int'(VEC[v][14:10]); d = int'(VEC[v][6:1]);
      gap_cfg = {VEC[v][14:10], VEC[v][9:7]};
      rd_off = -1; win_off = -1; ph = -1; found = 0;
      send(16'hC3 >> 1, 7);
      chip(1'b1);
      note(0);
      for (int off = 1; off <= 56; off++) begin
        chip((off > d && off <= d + 8) ? pat_b[7 - (off - d - 1)] : 1'b0);
        note(off);
      end
      chk($sformatf("R5 R9 vec%0d sync", v), int'(found), int'(VEC[v][0]));
      chk($sformatf("R3 R7 vec%0d readj offset", v), rd_off, g);
      chk($sformatf("R1 vec%0d phase", v), ph, int'(VEC[v][9:7]));
      chk($sformatf("R4 vec%0d window offset", v), win_off, g + 5);
    end

    // R8: disable in mid gap cancels the attempt
    gap_cfg = 8'h00;
    send(16'hC3, 8);
    repeat (3) chip(1'b0);
    @(negedge clk); dis = 1'b1;
    @(negedge clk); dis = 1'b0;
    found = 0; win_off = -1; rd_off = -1;
    repeat (2) begin chip(1'b0); note(0); end
    for (int i = 7; i >= 0; i--) begin chip(pat_b[i]); note(0); end
    repeat (20) begin chip(1'b0); note(0); end
    chk("R8 disable no sync", int'(found), 0);
    chk("R8 disable no window", win_off, -1);
    found = 0;
    send(16'hC3, 8);
    repeat (5) chip(1'b0);
    for (int i = 7; i >= 0; i--) begin chip(pat_b[i]); note(0); end
    chk("R8 search works after disable", int'(found), 1);

    // R6: expiry, then pattern A starting on the very next chip
    send(16'hC3, 8);
    repeat (19) chip(1'b0);
    chk("R6 window closed after limit chip", int'(o_win), 0);
    found = 0;
    send(16'hC3, 8);
    repeat (5) chip(1'b0);
    for (int i = 7; i >= 0; i--) begin chip(pat_b[i]); note(0); end
    chk("R6 restart on next chip", int'(found), 1);

    // R2: short patterns, upper pattern bits ignored
    len_a = 5'd4; pat_a = 16'hAB03;
    len_b = 5'd4; pat_b = 16'h5C35;
    repeat (4) chip(1'b0);
    found = 0; rd_off = -1;
    send(16'h0003, 4); note(0);
    chk("R2 short A match readj", rd_off, 0);
    repeat (5) chip(1'b0);
    for (int i = 3; i >= 0; i--) begin chip(pat_b[i]); note(0); end
    chk("R2 short B match", int'(found), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule